// File: doc/BRIEF.md
# MD4 Compression Round Engine

This block applies the MD4 compression function to a single 512-bit message block. The caller supplies four 32-bit chaining words and sixteen 32-bit message words. The core runs the 48-step schedule iteratively. It then adds each working word back onto the matching chaining word, modulo 2^32, and presents the 128-bit result. The parameter `STEPS_PER_CYCLE` sets how many steps are chained per clock. It must divide 48 evenly, so one block takes `48 / STEPS_PER_CYCLE` clock edges. Padding, byte ordering of a message stream and any register access belong to the surrounding logic. The core keeps nothing from one block to the next beyond what the caller passes in.

Both the chaining value and the message block enter on one valid/ready input. `in_ready` is high only while the core is idle, and that is the only back-pressure on the input. A block is captured on a rising edge where `in_valid` and `in_ready` are both high. `in_valid` raised while the core is busy has no effect. The output cannot be stalled. `out_valid` is a one-cycle pulse, and `out_digest` keeps the last result until the next one replaces it. A new block can be accepted in the same cycle as the pulse.

Top module: `md4_core`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_digest` is all zeros.
- R2: Chaining word n (n = 0..3, working registers a, b, c, d) sits in `in_chain[32n+31:32n]`. Message word k (k = 0..15) sits in `in_block[32k+31:32k]`. Result word n sits in `out_digest[32n+31:32n]`.
- R3: From the cycle after an acceptance until the result cycle, `in_ready` is 0, and any `in_valid` offered in that window changes neither the result nor the number of result pulses.
- R4: `out_valid` rises on the (48 / `STEPS_PER_CYCLE`)-th rising edge after the acceptance edge and stays high for exactly one cycle.
- R5: Each result word equals the matching input chaining word plus the final working word, wrapping modulo 2^32, including for all-ones operands.
- R6: The first 16 steps use the select function (x AND y) OR (NOT x AND z) with no added constant and rotations 3, 7, 11, 19 in turn. The next 16 steps use the majority function with constant 0x5A827999 and rotations 3, 5, 9, 13. The last 16 steps use three-input XOR with constant 0x6ED9EBA1 and rotations 3, 9, 11, 15. The working registers take the target role in the order a, d, c, b, and each update is rotl(target + f(other three) + word + constant, shift). With chaining words 0x67452301, 0xEFCDAB89, 0x98BADCFE, 0x10325476 and a block whose only nonzero word is word 0 = 0x00000080, the result words 0..3 are 0xE0CFD631, 0x31E96AD1, 0xD7593CB7, 0xC089C0E0.
- R7: The message word order is 0..15 in the first 16 steps. The second 16 steps use 0,4,8,12,1,5,9,13,2,6,10,14,3,7,11,15. The last 16 steps use 0,8,4,12,2,10,6,14,1,9,5,13,3,11,7,15.
- R8: `out_digest` changes only on the edge that raises `out_valid`, and otherwise holds its value.
- R9: `in_ready` is 1 in the result cycle, so a block offered there is accepted on the next edge and computed with its own chaining input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Chaining value and block are offered |
| in_ready | output | 1 | Core is idle and will capture an offer |
| in_chain | input | 128 | Four chaining words, word 0 lowest |
| in_block | input | 512 | Sixteen message words, word 0 lowest |
| out_valid | output | 1 | One-cycle pulse: result is valid |
| out_digest | output | 128 | Four result words, word 0 lowest |

## Verification
The result pulse for one block and the acceptance of the next block can fall in the same cycle. This happens because the core drops its busy state on the edge that presents the result. The bench provokes the overlap by keeping `in_valid` high with a second block from just after the first acceptance. The second block is then offered through the whole busy window and is captured on the first edge after the pulse. The bench judges the overlap by checking that `in_ready` is high in the pulse cycle and that the first digest is correct. It also checks that the second result arrives at the full latency and matches a model run on the second block's own chaining input.

// File: rtl/md4_pkg.sv
`timescale 1ns/1ps
package md4_pkg;

  localparam int WORD_W     = 32;
  localparam int MSG_WORDS  = 16;
  localparam int CHAIN_W    = 4;
  localparam int TOTAL_STEP = 48;
  localparam int IDX_W      = 6;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CHAIN_W-1:0][WORD_W-1:0] quad_t;
  typedef logic [MSG_WORDS-1:0][WORD_W-1:0] block_t;

  typedef enum logic [1:0] {
    RND_SEL = 2'd0,
    RND_MAJ = 2'd1,
    RND_PAR = 2'd2
  } round_e;

  typedef struct packed {
    round_e     rnd;
    logic [4:0] shamt;
    logic [3:0] widx;
    word_t      kconst;
  } step_ctl_t;

  localparam word_t K_MAJ = 32'h5A82_7999;
  localparam word_t K_PAR = 32'h6ED9_EBA1;

  function automatic word_t f_sel(word_t x, word_t y, word_t z);
    return (x & y) | (~x & z);
  endfunction

  function automatic word_t f_maj(word_t x, word_t y, word_t z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic word_t f_par(word_t x, word_t y, word_t z);
    return x ^ y ^ z;
  endfunction

  function automatic word_t rotl32(word_t x, logic [4:0] s);
    return (x << s) | (x >> (6'd32 - {1'b0, s}));
  endfunction

  // Rotation amount for a round and the step position inside a group of four.
  function automatic logic [4:0] shift_of(round_e r, logic [1:0] pos);
    logic [4:0] amt;
    unique case (r)
      RND_SEL: case (pos)
                 2'd0: amt = 5'd3;  2'd1: amt = 5'd7;
                 2'd2: amt = 5'd11; default: amt = 5'd19;
               endcase
      RND_MAJ: case (pos)
                 2'd0: amt = 5'd3;  2'd1: amt = 5'd5;
                 2'd2: amt = 5'd9;  default: amt = 5'd13;
               endcase
      default: case (pos)
                 2'd0: amt = 5'd3;  2'd1: amt = 5'd9;
                 2'd2: amt = 5'd11; default: amt = 5'd15;
               endcase
    endcase
    return amt;
  endfunction

endpackage

// File: rtl/md4_sched.sv
`timescale 1ns/1ps
module md4_sched
  import md4_pkg::*;
(
  input  logic [IDX_W-1:0] step_idx,
  output step_ctl_t        ctl
);

  logic [1:0] grp;
  logic [3:0] pos;

  always_comb begin
    grp = step_idx[5:4];
    pos = step_idx[3:0];
    unique case (grp)
      2'd0: begin
        ctl.rnd    = RND_SEL;
        ctl.kconst = '0;
        ctl.widx   = pos;
      end
      2'd1: begin
        ctl.rnd    = RND_MAJ;
        ctl.kconst = K_MAJ;
        ctl.widx   = {pos[1:0], pos[3:2]};
      end
      default: begin
        ctl.rnd    = RND_PAR;
        ctl.kconst = K_PAR;
        ctl.widx   = {pos[0], pos[1], pos[2], pos[3]};
      end
    endcase
    ctl.shamt = shift_of(ctl.rnd, pos[1:0]);
  end

endmodule

// File: rtl/md4_step.sv
`timescale 1ns/1ps
module md4_step
  import md4_pkg::*;
(
  input  step_ctl_t ctl,
  input  word_t     msg,
  input  quad_t     q_in,
  output quad_t     q_out
);

  word_t mix;
  word_t acc;
  word_t upd;

  always_comb begin
    unique case (ctl.rnd)
      RND_SEL: mix = f_sel(q_in[1], q_in[2], q_in[3]);
      RND_MAJ: mix = f_maj(q_in[1], q_in[2], q_in[3]);
      default: mix = f_par(q_in[1], q_in[2], q_in[3]);
    endcase
    acc = q_in[0] + mix + msg + ctl.kconst;
    upd = rotl32(acc, ctl.shamt);
    // Roles shift so the next target sits in slot 0: (D, A', B, C).
    q_out[0] = q_in[3];
    q_out[1] = upd;
    q_out[2] = q_in[1];
    q_out[3] = q_in[2];
  end

endmodule

// File: rtl/md4_core.sv
`timescale 1ns/1ps
module md4_core
  import md4_pkg::*;
#(
  parameter int STEPS_PER_CYCLE = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_chain,
  input  logic [511:0] in_block,
  output logic         out_valid,
  output logic [127:0] out_digest
);

  localparam int CYCLES = TOTAL_STEP / STEPS_PER_CYCLE;
  localparam int CNT_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  quad_t            work_q;
  quad_t            chain_q;
  block_t           blk_q;
  logic [IDX_W-1:0] base_idx;
  logic             take;
  logic             last;
  quad_t            lane [STEPS_PER_CYCLE+1];
  quad_t            sum_w;

  assign in_ready = ~busy_q;
  assign take     = in_valid & ~busy_q;
  assign last     = (cnt_q == CNT_W'(CYCLES - 1));
  assign base_idx = IDX_W'(int'(cnt_q) * STEPS_PER_CYCLE);
  assign lane[0]  = work_q;

  for (genvar g = 0; g < STEPS_PER_CYCLE; g++) begin : g_step
    logic [IDX_W-1:0] idx;
    step_ctl_t        ctl;
    assign idx = base_idx + IDX_W'(g);

    md4_sched u_sched (
      .step_idx (idx),
      .ctl      (ctl)
    );

    md4_step u_step (
      .ctl   (ctl),
      .msg   (blk_q[ctl.widx]),
      .q_in  (lane[g]),
      .q_out (lane[g+1])
    );
  end

  for (genvar n = 0; n < CHAIN_W; n++) begin : g_fold
    assign sum_w[n] = chain_q[n] + lane[STEPS_PER_CYCLE][n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      out_valid  <= 1'b0;
      out_digest <= '0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q     <= 1'b0;
          out_valid  <= 1'b1;
          out_digest <= sum_w;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      chain_q <= in_chain;
      work_q  <= in_chain;
      blk_q   <= in_block;
    end else if (busy_q) begin
      work_q <= lane[STEPS_PER_CYCLE];
    end
  end

endmodule

// File: rtl/md4_core_chk.sv
`timescale 1ns/1ps
module md4_core_chk #(
  parameter int STEPS_PER_CYCLE = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [127:0] out_digest
);

  localparam int CYC = 48 / STEPS_PER_CYCLE;

  logic [7:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  age_q <= '0;
    else if (in_valid && in_ready) age_q <= 8'd1;
    else if (out_valid)          age_q <= '0;
    else if (age_q != 0)         age_q <= age_q + 8'd1;
  end

  // R4
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (age_q == 8'(CYC + 1)));

  // R3
  accept_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (age_q != 0 && age_q <= 8'(CYC)));

  // R9
  ready_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R8
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_digest));

  if (CYC > 1) begin : g_pulse
    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
  end

endmodule

bind md4_core md4_core_chk #(.STEPS_PER_CYCLE(STEPS_PER_CYCLE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_digest (out_digest)
);

// File: tb/md4_core_tb.sv
`timescale 1ns/1ps
module md4_core_tb;

  localparam int SPC = 1;
  localparam int CYC = 48 / SPC;
  localparam logic [127:0] IV = {32'h10325476, 32'h98BADCFE, 32'hEFCDAB89, 32'h67452301};
  localparam int ORD2 [16] = '{0,4,8,12,1,5,9,13,2,6,10,14,3,7,11,15};
  localparam int ORD3 [16] = '{0,8,4,12,2,10,6,14,1,9,5,13,3,11,7,15};
  localparam int SH1 [4] = '{3,7,11,19};
  localparam int SH2 [4] = '{3,5,9,13};
  localparam int SH3 [4] = '{3,9,11,15};
  localparam int ROLE [4] = '{0,3,2,1};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_chain = '0;
  logic [511:0] in_block = '0;
  logic         out_valid;
  logic [127:0] out_digest;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  md4_core #(.STEPS_PER_CYCLE(SPC)) u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_chain (in_chain), .in_block (in_block),
    .out_valid (out_valid), .out_digest (out_digest)
  );

  function automatic logic [127:0] ref_compress(input logic [127:0] ch, input logic [511:0] m);
    logic [31:0] v [4];
    logic [31:0] x, y, z, fx, k, t;
    int tgt, wi, s;
    for (int n = 0; n < 4; n++) v[n] = ch[32*n +: 32];
    for (int i = 0; i < 48; i++) begin
      tgt = ROLE[i % 4];
      x = v[(tgt + 1) % 4];
      y = v[(tgt + 2) % 4];
      z = v[(tgt + 3) % 4];
      if (i < 16) begin
        fx = (x & y) | (~x & z); k = 32'h0; wi = i; s = SH1[i % 4];
      end else if (i < 32) begin
        fx = (x & y) | (x & z) | (y & z); k = 32'h5A827999; wi = ORD2[i - 16]; s = SH2[i % 4];
      end else begin
        fx = x ^ y ^ z; k = 32'h6ED9EBA1; wi = ORD3[i - 32]; s = SH3[i % 4];
      end
      t = v[tgt] + fx + m[32*wi +: 32] + k;
      v[tgt] = (t << s) | (t >> (32 - s));
    end
    return {v[3] + ch[127:96], v[2] + ch[95:64], v[1] + ch[63:32], v[0] + ch[31:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offers a block, waits for the result, returns digest and edge count.
  task automatic run_block(input logic [127:0] ch, input logic [511:0] m,
                           output logic [127:0] dig, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_chain = ch; in_block = m;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    dig = out_digest;
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 128'd1);
    check(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'd0);
    check(out_digest == '0, "R1 out_digest", out_digest, '0);
  endtask

  task automatic t_known_answer();
    logic [127:0] d; int lat;
    logic [127:0] kat = {32'hC089C0E0, 32'hD7593CB7, 32'h31E96AD1, 32'hE0CFD631};
    run_block(IV, 512'h80, d, lat);
    check(d == kat, "R6 R2 known answer", d, kat);
    check(lat == CYC, "R4 latency", 128'(lat), 128'(CYC));
    @(negedge clk);
    check(out_valid == 1'b0, "R4 pulse width", 128'(out_valid), 128'd0);
    check(out_digest == kat, "R8 hold", out_digest, kat);
  endtask

  task automatic t_random_blocks();
    logic [127:0] d, e; logic [511:0] m; int lat;
    for (int r = 0; r < 4; r++) begin
      for (int w = 0; w < 16; w++) m[32*w +: 32] = $urandom;
      e = ref_compress(IV, m);
      run_block(IV, m, d, lat);
      check(d == e, "R7 word order random block", d, e);
    end
  endtask

  task automatic t_custom_chain();
    logic [127:0] d, e, ch; logic [511:0] m; int lat;
    ch = {$urandom, $urandom, $urandom, $urandom};
    for (int w = 0; w < 16; w++) m[32*w +: 32] = $urandom;
    e = ref_compress(ch, m);
    run_block(ch, m, d, lat);
    check(d == e, "R5 custom chaining", d, e);
    e = ref_compress({128{1'b1}}, {512{1'b1}});
    run_block({128{1'b1}}, {512{1'b1}}, d, lat);
    check(d == e, "R5 all-ones wrap", d, e);
  endtask

  task automatic t_ignore_busy();
    logic [127:0] e, d; logic [511:0] ma, mc; int pulses;
    for (int w = 0; w < 16; w++) begin ma[32*w +: 32] = $urandom; mc[32*w +: 32] = $urandom; end
    e = ref_compress(IV, ma);
    @(negedge clk);
    in_valid = 1'b1; in_chain = IV; in_block = ma;
    @(negedge clk);
    in_chain = ~IV; in_block = mc;
    pulses = 0;
    for (int c = 0; c < 6; c++) begin
      if (c == 3) check(in_ready == 1'b0, "R3 ready low while busy", 128'(in_ready), 128'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int c = 0; c < 2 * CYC; c++) begin
      if (out_valid) begin pulses++; d = out_digest; end
      @(negedge clk);
    end
    check(pulses == 1, "R3 one pulse only", 128'(pulses), 128'd1);
    check(d == e, "R3 busy offer ignored", d, e);
  endtask

  task automatic t_back_to_back();
    logic [127:0] ea, eb, cb, d; logic [511:0] ma, mb; int lat;
    for (int w = 0; w < 16; w++) begin ma[32*w +: 32] = $urandom; mb[32*w +: 32] = $urandom; end
    cb = {$urandom, $urandom, $urandom, $urandom};
    ea = ref_compress(IV, ma);
    eb = ref_compress(cb, mb);
    @(negedge clk);
    in_valid = 1'b1; in_chain = IV; in_block = ma;
    @(negedge clk);
    in_chain = cb; in_block = mb;
    lat = 0;
    while (!out_valid && lat < 400) begin @(negedge clk); lat++; end
    check(out_digest == ea, "R9 first result", out_digest, ea);
    check(in_ready == 1'b1, "R9 ready in result cycle", 128'(in_ready), 128'd1);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 400) begin @(negedge clk); lat++; end
    check(out_digest == eb, "R9 second result own chain", out_digest, eb);
    check(lat == CYC, "R4 second latency", 128'(lat), 128'(CYC));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known_answer();
    t_random_blocks();
    t_custom_chain();
    t_ignore_busy();
    t_back_to_back();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule